// File: doc/BRIEF.md
# Accumulator Bit and Digit Rotator

This execution unit rotates an 8-bit accumulator by one bit or moves 4-bit digits between the accumulator and a byte held in memory. A one-bit rotate either cycles the accumulator alone, copying the bit that leaves into the carry, or passes the bits through the carry flag as a ninth bit. A digit rotate reads one memory byte, cycles three nibbles around (the accumulator low nibble and both nibbles of the memory byte), and writes the updated byte back.

The surrounding core presents an operation code, the current accumulator and carry, and a start strobe. It then waits for the one-cycle `done` pulse, at which point the new accumulator and carry are on the outputs. The operands are captured on the start edge, so the inputs may change freely while an operation runs. Memory is reached through a synchronous port: a one-cycle read strobe, read data returned in the following cycle, and a one-cycle write strobe carrying the write data. The `fast_mem` input selects the shorter digit sequence used for fast internal memory.

Top module: `acc_rot_unit`

## Requirements
- R1: Operation code 0 (right rotate) makes bit 0 the new bit 7 and the new carry, and moves every other bit down one place.
- R2: Operation code 1 (left rotate) makes bit 7 the new bit 0 and the new carry, and moves every other bit up one place.
- R3: Operation code 2 (right rotate through carry) sets the new carry from bit 0 and the new bit 7 from the old carry, and moves every other bit down one place.
- R4: Operation code 3 (left rotate through carry) sets the new carry from bit 7 and the new bit 0 from the old carry, and moves every other bit up one place.
- R5: Operation code 4 (right digit rotate) sets the new accumulator bits 3:0 to memory bits 3:0, the written memory bits 7:4 to the old accumulator bits 3:0, and the written memory bits 3:0 to the old memory bits 7:4.
- R6: Operation code 5 (left digit rotate) sets the new accumulator bits 3:0 to memory bits 7:4, the written memory bits 3:0 to the old accumulator bits 3:0, and the written memory bits 7:4 to the old memory bits 3:0.
- R7: A digit rotate leaves accumulator bits 7:4 and the carry flag unchanged.
- R8: Counting the cycle in which start is sampled as cycle 1, a one-bit rotate raises `done` for exactly one cycle in cycle 2. From that cycle on, `acc_out` and `cy_out` hold the result until the next operation completes.
- R9: A digit rotate raises `mem_re` for one cycle in cycle 2 and samples `mem_rdata` at the end of cycle 3. It raises `mem_we` and `done` together for one cycle in its final cycle, with `mem_wdata` and `acc_out` valid in that cycle. The final cycle is cycle 10 when `fast_mem` is 1 at start and cycle 12 when it is 0.
- R10: A start strobe sampled while an operation is in progress, including its final cycle, is ignored: the running operation and its results are unaffected and no further operation follows.
- R11: Operation codes 6 and 7 complete like a one-bit rotate (done in cycle 2), return the captured accumulator and carry unchanged, and make no memory access.
- R12: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| op | input | 3 | Operation code (0 to 7) |
| acc_in | input | 8 | Accumulator operand |
| cy_in | input | 1 | Carry operand |
| fast_mem | input | 1 | 1 selects the 10-cycle digit sequence, 0 the 12-cycle one |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_re` |
| acc_out | output | 8 | Result accumulator |
| cy_out | output | 1 | Result carry |
| done | output | 1 | One-cycle completion pulse |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |

## Verification
For a bit rotate or a reserved code, `done` and the new accumulator and carry are due in the cycle after the start edge. For a digit rotate, `mem_re` is due one cycle after the start edge. `mem_rdata` is consumed on the edge that closes cycle 3, and `mem_we`, `mem_wdata`, `done` and the updated accumulator are due 9 or 11 cycles after the start edge. The bench keeps a cycle counter of its own, advanced on each rising edge, that predicts every output for the coming cycle. It compares that prediction with the outputs at the falling edge, half a period after the registers settle. It also drives junk on `mem_rdata` outside the two cycles after a read, so a capture in the wrong cycle yields a wrong digit.

// File: rtl/acc_rot_pkg.sv
package acc_rot_pkg;

  localparam int ACC_W = 8;
  localparam int NIB_W = ACC_W / 2;

  typedef enum logic [2:0] {
    OP_ROR   = 3'd0,
    OP_ROL   = 3'd1,
    OP_RORC  = 3'd2,
    OP_ROLC  = 3'd3,
    OP_DIGR  = 3'd4,
    OP_DIGL  = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } rot_op_e;

  typedef struct packed {
    logic             cy;
    logic [ACC_W-1:0] acc;
  } bit_res_t;

  typedef struct packed {
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] mem;
  } dig_res_t;

  function automatic logic op_is_digit(rot_op_e o);
    return (o == OP_DIGR) || (o == OP_DIGL);
  endfunction

  // One-bit rotates; reserved codes pass the operands through.
  function automatic bit_res_t bit_rotate(rot_op_e o, logic [ACC_W-1:0] a, logic c);
    bit_res_t r;
    case (o)
      OP_ROR:  begin r.acc = {a[0], a[ACC_W-1:1]};  r.cy = a[0];       end
      OP_ROL:  begin r.acc = {a[ACC_W-2:0], a[ACC_W-1]}; r.cy = a[ACC_W-1]; end
      OP_RORC: begin r.acc = {c, a[ACC_W-1:1]};     r.cy = a[0];       end
      OP_ROLC: begin r.acc = {a[ACC_W-2:0], c};     r.cy = a[ACC_W-1]; end
      default: begin r.acc = a;                     r.cy = c;          end
    endcase
    return r;
  endfunction

  // Nibble cycling between the accumulator low digit and a memory byte.
  function automatic dig_res_t digit_rotate(rot_op_e o, logic [ACC_W-1:0] a, logic [ACC_W-1:0] m);
    dig_res_t r;
    if (o == OP_DIGL) begin
      r.acc = {a[ACC_W-1:NIB_W], m[ACC_W-1:NIB_W]};
      r.mem = {m[NIB_W-1:0], a[NIB_W-1:0]};
    end else begin
      r.acc = {a[ACC_W-1:NIB_W], m[NIB_W-1:0]};
      r.mem = {a[NIB_W-1:0], m[ACC_W-1:NIB_W]};
    end
    return r;
  endfunction

endpackage

// File: rtl/acc_rot_seq.sv
module acc_rot_seq #(
  parameter int BIT_CLKS      = 2,
  parameter int DIG_FAST_CLKS = 10,
  parameter int DIG_SLOW_CLKS = 12,
  parameter int RD_CYC        = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic digit_req,
  input  logic fast_mem,
  output logic accept,
  output logic rd_strobe,
  output logic cap_strobe,
  output logic commit,
  output logic final_cyc,
  output logic dig_active
);

  localparam int MAXC_A  = (DIG_FAST_CLKS > DIG_SLOW_CLKS) ? DIG_FAST_CLKS : DIG_SLOW_CLKS;
  localparam int MAXC    = (MAXC_A > BIT_CLKS) ? MAXC_A : BIT_CLKS;
  localparam int CW      = $clog2(MAXC + 1);
  localparam int CAP_CYC = RD_CYC + 1;

  logic [CW-1:0] cnt_q, len_q, len_sel, cnt_nxt;
  logic          busy_q, dig_q;

  assign len_sel = digit_req ? (fast_mem ? CW'(DIG_FAST_CLKS) : CW'(DIG_SLOW_CLKS))
                             : CW'(BIT_CLKS);
  assign cnt_nxt    = cnt_q + CW'(1);
  assign accept     = start && !busy_q;
  assign final_cyc  = busy_q && (cnt_q == len_q);
  assign dig_active = busy_q && dig_q;
  assign rd_strobe  = dig_active && (cnt_q == CW'(RD_CYC));
  assign cap_strobe = dig_active && (cnt_q == CW'(CAP_CYC));
  assign commit     = accept ? (len_sel == CW'(2))
                             : (busy_q && !final_cyc && (cnt_nxt == len_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dig_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      dig_q  <= digit_req;
      cnt_q  <= CW'(2);
      len_q  <= len_sel;
    end else if (final_cyc) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_nxt;
    end
  end

  AST_BIT_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !digit_req |=> final_cyc);                               // R8
  AST_FINAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    final_cyc |=> !final_cyc);                                         // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !final_cyc |=> busy_q && $stable(len_q) && $stable(dig_q)); // R10
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe && cap_strobe);                           // R9

endmodule

// File: rtl/acc_rot_datapath.sv
module acc_rot_datapath
  import acc_rot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             commit,
  input  logic             cap_strobe,
  input  logic             final_cyc,
  input  rot_op_e          op_in,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             cy_in,
  input  logic [ACC_W-1:0] mem_rdata,
  output logic [ACC_W-1:0] acc_out,
  output logic             cy_out,
  output logic [ACC_W-1:0] mem_wdata
);

  rot_op_e          op_q;
  logic [ACC_W-1:0] acc_q;
  logic             cy_q;
  dig_res_t         dres_q;
  bit_res_t         bres;
  logic             bit_commit, dig_commit;

  assign bres       = bit_rotate(op_in, acc_in, cy_in);
  assign bit_commit = commit && accept;
  assign dig_commit = commit && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_ROR;
      acc_q  <= '0;
      cy_q   <= 1'b0;
      dres_q <= '0;
    end else begin
      if (accept) begin
        op_q  <= op_in;
        acc_q <= acc_in;
        cy_q  <= cy_in;
      end
      if (cap_strobe) dres_q <= digit_rotate(op_q, acc_q, mem_rdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out   <= '0;
      cy_out    <= 1'b0;
      mem_wdata <= '0;
    end else if (bit_commit) begin
      acc_out <= bres.acc;
      cy_out  <= bres.cy;
    end else if (dig_commit) begin
      acc_out   <= dres_q.acc;
      cy_out    <= cy_q;
      mem_wdata <= dres_q.mem;
    end
  end

  AST_DIGIT_KEEPS_HIGH_AND_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    final_cyc && op_is_digit(op_q) |->
      cy_out == cy_q && acc_out[ACC_W-1:NIB_W] == acc_q[ACC_W-1:NIB_W]); // R7
  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> $stable(acc_q) && $stable(op_q));                    // R10

endmodule

// File: rtl/acc_rot_unit.sv
module acc_rot_unit
  import acc_rot_pkg::*;
#(
  parameter int BIT_CLKS      = 2,
  parameter int DIG_FAST_CLKS = 10,
  parameter int DIG_SLOW_CLKS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             cy_in,
  input  logic             fast_mem,
  input  logic [ACC_W-1:0] mem_rdata,
  output logic [ACC_W-1:0] acc_out,
  output logic             cy_out,
  output logic             done,
  output logic             mem_re,
  output logic             mem_we,
  output logic [ACC_W-1:0] mem_wdata
);

  rot_op_e op_e;
  logic    digit_req, accept, rd_strobe, cap_strobe, commit, final_cyc, dig_active;

  assign op_e      = rot_op_e'(op);
  assign digit_req = op_is_digit(op_e);

  acc_rot_seq #(
    .BIT_CLKS      (BIT_CLKS),
    .DIG_FAST_CLKS (DIG_FAST_CLKS),
    .DIG_SLOW_CLKS (DIG_SLOW_CLKS),
    .RD_CYC        (2)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .digit_req  (digit_req),
    .fast_mem   (fast_mem),
    .accept     (accept),
    .rd_strobe  (rd_strobe),
    .cap_strobe (cap_strobe),
    .commit     (commit),
    .final_cyc  (final_cyc),
    .dig_active (dig_active)
  );

  acc_rot_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .commit     (commit),
    .cap_strobe (cap_strobe),
    .final_cyc  (final_cyc),
    .op_in      (op_e),
    .acc_in     (acc_in),
    .cy_in      (cy_in),
    .mem_rdata  (mem_rdata),
    .acc_out    (acc_out),
    .cy_out     (cy_out),
    .mem_wdata  (mem_wdata)
  );

  assign done   = final_cyc;
  assign mem_re = rd_strobe;
  assign mem_we = final_cyc && dig_active;

  AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> done);                                                   // R9
  AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> !done && !mem_we);                                       // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !done && !mem_re && !mem_we && acc_out == '0);           // R12

endmodule

// File: tb/acc_rot_unit_test.sv
`timescale 1ns/1ps
module acc_rot_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] op_in = 3'd0;
  logic [7:0] acc_in = 8'd0;
  logic       cy_in = 1'b0;
  logic       fast_mem = 1'b1;
  logic [7:0] mem_rdata = 8'd0;
  logic [7:0] acc_out, mem_wdata;
  logic       cy_out, done, mem_re, mem_we;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  acc_rot_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_in), .acc_in(acc_in),
    .cy_in(cy_in), .fast_mem(fast_mem), .mem_rdata(mem_rdata),
    .acc_out(acc_out), .cy_out(cy_out), .done(done), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference of the requirement formulas.
  task automatic ref_calc(int o, int a, int c, int m, output int ea, output int ec, output int em);
    em = 0;
    case (o)
      0: begin ec = a & 1;        ea = (a >> 1) | ((a & 1) << 7);   end
      1: begin ec = (a >> 7) & 1; ea = ((a << 1) & 255) | (a >> 7); end
      2: begin ec = a & 1;        ea = (a >> 1) | (c << 7);         end
      3: begin ec = (a >> 7) & 1; ea = ((a << 1) & 255) | c;        end
      4: begin ec = c; ea = (a & 240) | (m & 15); em = ((a & 15) << 4) | (m >> 4); end
      5: begin ec = c; ea = (a & 240) | (m >> 4); em = ((m & 15) << 4) | (a & 15); end
      default: begin ec = c; ea = a; end
    endcase
  endtask

  function automatic string tag_of(int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R11";
    endcase
  endfunction

  // Cycle-counting model, advanced on each rising edge.
  int m_busy = 0, m_cycle = 0, m_len = 0, m_op = -1, m_acc = 0, m_cy = 0, m_mem = 0, m_dig = 0;
  int e_acc = 0, e_cy = 0, e_wdata = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_op = -1; e_acc = 0; e_cy = 0; e_wdata = 0;
    end else if (m_busy != 0) begin
      if (m_cycle == m_len) m_busy = 0;
      else begin
        if (m_dig != 0 && m_cycle == 3) m_mem = mem_rdata;
        m_cycle++;
        if (m_dig != 0 && m_cycle == m_len) begin
          int ea, ec, em;
          ref_calc(m_op, m_acc, m_cy, m_mem, ea, ec, em);
          e_acc = ea; e_cy = ec; e_wdata = em;
        end
      end
    end else if (start) begin
      m_busy = 1; m_cycle = 2; m_op = op_in; m_acc = acc_in; m_cy = cy_in;
      m_dig = (op_in == 4 || op_in == 5) ? 1 : 0;
      m_len = (m_dig != 0) ? (fast_mem ? 10 : 12) : 2;
      if (m_dig == 0) begin
        int ea, ec, em;
        ref_calc(m_op, m_acc, m_cy, 0, ea, ec, em);
        e_acc = ea; e_cy = ec;
      end
    end
  end

  // Compare at the falling edge, every cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      int e_done, e_re, e_we;
      string t;
      e_done = (m_busy != 0 && m_cycle == m_len) ? 1 : 0;
      e_re   = (m_busy != 0 && m_dig != 0 && m_cycle == 2) ? 1 : 0;
      e_we   = (e_done != 0 && m_dig != 0) ? 1 : 0;
      t = (m_op < 0) ? "R12" : tag_of(m_op);
      chk((m_dig != 0) ? "R9" : "R8", "done", done, e_done);
      chk("R9", "mem_re", mem_re, e_re);
      chk("R9", "mem_we", mem_we, e_we);
      chk(t, "acc_out", acc_out, e_acc);
      chk(t, "cy_out", cy_out, e_cy);
      if (e_we != 0) chk(t, "mem_wdata", mem_wdata, e_wdata);
    end
  end

  // Synchronous memory: data valid the cycle after a read, junk otherwise.
  logic [7:0] bench_mem = 8'd0;
  int hold = 0;
  always @(negedge clk) begin
    if (mem_re) begin mem_rdata <= bench_mem; hold = 1; end
    else if (hold != 0) hold = 0;
    else mem_rdata <= 8'($urandom);
    if (mem_we) bench_mem <= mem_wdata;
  end

  task automatic run_op(int o, int a, int c, int fast, int m, int poke);
    int ea, ec, em;
    ref_calc(o, a, c, m, ea, ec, em);
    bench_mem = 8'(m);
    @(negedge clk);
    start = 1'b1; op_in = 3'(o); acc_in = 8'(a); cy_in = 1'(c); fast_mem = 1'(fast);
    @(negedge clk);
    start = (poke != 0); acc_in = 8'($urandom); cy_in = 1'($urandom);
    op_in = 3'($urandom); fast_mem = 1'($urandom);
    while (!done) @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(tag_of(o), "final acc", acc_out, ea);
    chk(tag_of(o), "final carry", cy_out, ec);
    if (o == 4 || o == 5) begin
      chk("R7", "acc high nibble", acc_out >> 4, a >> 4);
      chk("R7", "carry kept", cy_out, c);
      chk(tag_of(o), "memory byte", bench_mem, em);
    end
    if (poke != 0) begin
      @(negedge clk);
      chk("R10", "no extra done", done, 0);
      chk("R10", "result kept", acc_out, ea);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "reset acc_out", acc_out, 0);
    chk("R12", "reset cy_out", cy_out, 0);
    chk("R12", "reset done", done, 0);
    chk("R12", "reset mem_re", mem_re, 0);
    chk("R12", "reset mem_we", mem_we, 0);
    chk("R12", "reset mem_wdata", mem_wdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(0, 8'h01, 0, 1, 0, 0);      // R1
    run_op(0, 8'hA6, 1, 1, 0, 0);      // R1
    run_op(1, 8'h80, 0, 1, 0, 0);      // R2
    run_op(1, 8'h5B, 1, 0, 0, 0);      // R2
    run_op(2, 8'h01, 0, 1, 0, 0);      // R3
    run_op(2, 8'h00, 1, 1, 0, 0);      // R3
    run_op(3, 8'h80, 0, 1, 0, 0);      // R4
    run_op(3, 8'h00, 1, 1, 0, 0);      // R4
    run_op(4, 8'hA5, 1, 1, 8'h3C, 0);  // R5 fast
    run_op(4, 8'h7E, 0, 0, 8'hD1, 0);  // R5 slow
    run_op(5, 8'hA5, 1, 1, 8'h3C, 0);  // R6 fast
    run_op(5, 8'h19, 0, 0, 8'hF2, 0);  // R6 slow
    run_op(6, 8'hC3, 1, 1, 8'h11, 0);  // R11
    run_op(7, 8'h3C, 0, 0, 8'h22, 0);  // R11
    run_op(4, 8'h96, 1, 0, 8'h4B, 1);  // R10 start held during digit op
    run_op(2, 8'h81, 1, 1, 0, 1);      // R10 start held during bit op
    for (int i = 0; i < 200; i++)
      run_op(int'($urandom_range(0, 7)), int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
             int'($urandom_range(0, 1)), int'($urandom_range(0, 255)), int'($urandom_range(0, 3) == 0));
    finish_up();
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

endmodule